// File: doc/BRIEF.md
# Start-up Reset Time-out Sequencer

The sequencer keeps a core reset asserted after a power-on, a brown-out or a wake from a low-power state until the start-up delays for the selected clock source have run out. Up to three stages run in a fixed order. The first is a power-up timer counted in timebase ticks. The second is an oscillator settle count that counts edges of the oscillator clock itself. The third is a lock wait for the frequency multiplier, also counted in ticks. Which stages apply depends on the clock-mode code, on an active-low power-up-timer enable, and on the kind of event that started the sequence.

Power-on and brown-out detection happen elsewhere. Those events arrive as single-cycle pulses in the `clk` domain. The clock mode and the timer enable are captured when a sequence starts, so a change to them takes effect only at the next event. The external reset pin is synchronized into the `clk` domain and can extend the hold. Three flags report which stages finished in the current sequence.

Top module: `startup_hold_seq`

## Requirements
- R1: After `rst_n` is released, `core_reset` is 1 and all three done flags are 0, and this holds until the first power-on or brown-out pulse.
- R2: A power-on or brown-out pulse taken while `pwrt_en_n` is 0 starts a power-up stage lasting `PWRT_TICKS` ticks. This stage comes before every other stage, and `pwrt_done` is set when it ends.
- R3: A power-on or brown-out pulse taken while `pwrt_en_n` is 1 skips the power-up stage, and `pwrt_done` stays 0.
- R4: The crystal modes are the codes with bit 2 set (4, 5, 6, 7). In these modes, an oscillator settle stage of `OSC_CYCLES` rising edges of `osc_clk` follows the power-up stage, and `ost_done` is set when it ends.
- R5: Mode code 7 (crystal with multiplier) adds a lock stage of `PLL_TICKS` ticks after the settle stage and then sets `pll_done`. `pll_done` is never set unless `ost_done` is already set.
- R6: Mode codes 0 to 3 (external clock, RC, internal oscillator) use only the power-up stage. `ost_done` and `pll_done` stay 0.
- R7: A wake pulse accepted while the reset is released never runs the power-up stage, whatever `pwrt_en_n` holds. Crystal modes run the settle stage, and code 7 also runs the lock stage. Codes 0 to 3 release `core_reset` within 2 cycles.
- R8: While the two-stage-synchronized `ext_rst_n` is low, `core_reset` is 1. After the stages complete, the reset releases 2 cycles after the pin goes high.
- R9: A power-on or brown-out pulse during any stage puts `core_reset` at 1 and all flags at 0 on the next cycle, then runs the full sequence again, timed from the new pulse.
- R10: Changes to `clk_mode` or `pwrt_en_n` after a sequence has started do not change that sequence.
- R11: A wake pulse is ignored while a sequence is in progress and before the first power-on pulse.
- R12: The tick-counted stages advance only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer logic |
| tick | input | 1 | Timebase enable, one cycle per tick |
| osc_clk | input | 1 | Oscillator clock counted during the settle stage |
| por_pulse | input | 1 | Power-on event pulse |
| bor_pulse | input | 1 | Brown-out event pulse |
| pm_exit_pulse | input | 1 | Wake-from-low-power event pulse |
| clk_mode | input | 3 | Clock-mode code; bit 2 marks crystal modes, 7 adds the multiplier |
| pwrt_en_n | input | 1 | Power-up-timer enable, 0 = timer applies |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| core_reset | output | 1 | Core reset, 1 = held |
| pwrt_done | output | 1 | Power-up stage completed in this sequence |
| ost_done | output | 1 | Oscillator settle stage completed in this sequence |
| pll_done | output | 1 | Lock stage completed in this sequence |

## Verification
Power-on and wake events are applied across every clock-mode class, with the timer enable in both states. The hold length falls into separate windows for no stage, power-up only, settle only, power-up plus settle, and all three, and the flags show which stages ran. Events are also placed mid-sequence: a brown-out during the settle stage has to restart from zero, while a wake pulse or a mode change at that point must leave the hold length as it was. A sparse tick pattern stretches only the tick-counted stages, which tells tick gating apart from cycle counting. Holding the pin low past the end of the sequence shows the release follows the later of the two causes.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int          CLK_MODE_W  = 3;
  localparam int          CRYSTAL_BIT = 2;
  localparam logic [2:0]  PLL_MODE    = 3'd7;

  typedef enum logic [2:0] {
    ST_WAIT    = 3'd0,
    ST_START   = 3'd1,
    ST_PWRT    = 3'd2,
    ST_OST_ARM = 3'd3,
    ST_OST     = 3'd4,
    ST_PLL     = 3'd5,
    ST_DONE    = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic                  wake;
    logic [CLK_MODE_W-1:0] mode;
    logic                  pwrt_off;
  } seq_cfg_t;

  function automatic logic is_crystal(logic [CLK_MODE_W-1:0] m);
    return m[CRYSTAL_BIT];
  endfunction

  function automatic logic is_pll(logic [CLK_MODE_W-1:0] m);
    return m == PLL_MODE;
  endfunction

  // first stage that applies to a freshly captured configuration
  function automatic seq_state_e first_stage(seq_cfg_t c);
    if (!c.wake && !c.pwrt_off) return ST_PWRT;
    if (is_crystal(c.mode))     return ST_OST_ARM;
    return ST_DONE;
  endfunction

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= {stg_q[STAGES-2:0], d};
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);

  localparam int             CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0]  LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = !run || (tick && (cnt_q != LIM));

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = run && (cnt_q == LIM);

endmodule

// File: rtl/seq_osc_count.sv
module seq_osc_count #(
  parameter int OSC_CYCLES = 1024,
  parameter int STAGES     = 2
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic run_req,
  output logic done
);

  localparam int            CW  = $clog2(OSC_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(OSC_CYCLES);

  logic [1:0]    orst_q;
  logic          osc_rst_n;
  logic          run_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;

  // local reset: asserts at once, releases on the oscillator clock
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) orst_q <= 2'b00;
    else        orst_q <= {orst_q[0], 1'b1};
  end
  assign osc_rst_n = orst_q[1];

  seq_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_run_sync (
    .clk   (osc_clk),
    .rst_n (osc_rst_n),
    .d     (run_req),
    .q     (run_s)
  );

  assign cnt_en = !run_s || (cnt_q != LIM);

  always_comb begin
    if (!run_s) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
    done_d = run_s && (cnt_q == LIM);
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

endmodule

// File: rtl/startup_hold_seq.sv
module startup_hold_seq
  import seq_pkg::*;
#(
  parameter int PWRT_TICKS  = 655,
  parameter int PLL_TICKS   = 20,
  parameter int OSC_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  osc_clk,
  input  logic                  por_pulse,
  input  logic                  bor_pulse,
  input  logic                  pm_exit_pulse,
  input  logic [CLK_MODE_W-1:0] clk_mode,
  input  logic                  pwrt_en_n,
  input  logic                  ext_rst_n,
  output logic                  core_reset,
  output logic                  pwrt_done,
  output logic                  ost_done,
  output logic                  pll_done
);

  seq_state_e state_q, state_d;
  seq_cfg_t   cfg_q, cfg_d;
  logic       cfg_en;
  logic       power_evt;
  logic       pin_s;
  logic       pwrt_run, pll_run;
  logic       pwrt_exp, pll_exp;
  logic       ost_req_q, ost_req_d;
  logic       ost_done_raw, ost_done_s;
  logic [2:0] flag_q, flag_d;

  assign power_evt = por_pulse || bor_pulse;

  seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_rst_n),
    .q     (pin_s)
  );

  seq_tick_timer #(.LIMIT(PWRT_TICKS)) u_pwrt_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (pwrt_run),
    .tick    (tick),
    .expired (pwrt_exp)
  );

  seq_tick_timer #(.LIMIT(PLL_TICKS)) u_pll_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (pll_run),
    .tick    (tick),
    .expired (pll_exp)
  );

  seq_osc_count #(.OSC_CYCLES(OSC_CYCLES), .STAGES(SYNC_STAGES)) u_osc_count (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .run_req (ost_req_q),
    .done    (ost_done_raw)
  );

  seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ost_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ost_done_raw),
    .q     (ost_done_s)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cfg_en  = 1'b0;
    if (power_evt) begin
      cfg_en  = 1'b1;
      state_d = ST_START;
    end else begin
      case (state_q)
        ST_WAIT:    state_d = ST_WAIT;
        ST_START:   state_d = first_stage(cfg_q);
        ST_PWRT:    if (pwrt_exp)
                      state_d = is_crystal(cfg_q.mode) ? ST_OST_ARM : ST_DONE;
        ST_OST_ARM: if (!ost_done_s) state_d = ST_OST;
        ST_OST:     if (ost_done_s)
                      state_d = is_pll(cfg_q.mode) ? ST_PLL : ST_DONE;
        ST_PLL:     if (pll_exp) state_d = ST_DONE;
        ST_DONE:    if (pm_exit_pulse) begin
                      cfg_en  = 1'b1;
                      state_d = ST_START;
                    end
        default:    state_d = ST_WAIT;
      endcase
    end
  end

  always_comb begin
    cfg_d.wake     = !power_evt;
    cfg_d.mode     = clk_mode;
    cfg_d.pwrt_off = pwrt_en_n;
  end

  // stage completion flags: cleared at sequence start, set on stage exit
  always_comb begin
    flag_d = flag_q;
    if (cfg_en) begin
      flag_d = 3'b000;
    end else begin
      if (state_q == ST_PWRT && pwrt_exp)  flag_d[0] = 1'b1;
      if (state_q == ST_OST  && ost_done_s) flag_d[1] = 1'b1;
      if (state_q == ST_PLL  && pll_exp)   flag_d[2] = 1'b1;
    end
  end

  assign ost_req_d = (state_d == ST_OST);
  assign pwrt_run  = (state_q == ST_PWRT);
  assign pll_run   = (state_q == ST_PLL);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_WAIT;
      flag_q    <= 3'b000;
      ost_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      flag_q    <= flag_d;
      ost_req_q <= ost_req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign core_reset = (state_q != ST_DONE) || !pin_s;
  assign pwrt_done  = flag_q[0];
  assign ost_done   = flag_q[1];
  assign pll_done   = flag_q[2];

endmodule

// File: rtl/startup_hold_seq_chk.sv
module startup_hold_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic por_pulse,
  input logic bor_pulse,
  input logic ext_rst_n,
  input logic core_reset,
  input logic pwrt_done,
  input logic ost_done,
  input logic pll_done,
  input logic pwrt_run,
  input logic ost_req,
  input logic pll_run
);

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (por_pulse || bor_pulse) |=> (core_reset && !pwrt_done && !ost_done && !pll_done));

  // R8
  pin_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ext_rst_n, 2) |-> core_reset);

  // R8
  release_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_reset |-> $past(ext_rst_n, 2));

  // R5
  lock_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_done) |-> ost_done);

  // R2
  pwrt_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrt_done) |-> $past(pwrt_run));

  // R4
  single_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwrt_run, ost_req, pll_run}));

endmodule

bind startup_hold_seq startup_hold_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_pulse  (por_pulse),
  .bor_pulse  (bor_pulse),
  .ext_rst_n  (ext_rst_n),
  .core_reset (core_reset),
  .pwrt_done  (pwrt_done),
  .ost_done   (ost_done),
  .pll_done   (pll_done),
  .pwrt_run   (pwrt_run),
  .ost_req    (ost_req_q),
  .pll_run    (pll_run)
);

// File: tb/startup_hold_seq_test.sv
module startup_hold_seq_test;

  localparam int P  = 40;
  localparam int L  = 20;
  localparam int O  = 32;
  localparam int NV = 12;
  // {wake, mode[2:0], pwrt_en_n, exp pwrt, exp ost, exp pll}
  localparam logic [7:0] VEC [NV] = '{
    8'b0_000_0_100, 8'b0_011_0_100, 8'b0_100_0_110, 8'b0_110_0_110,
    8'b0_111_0_111, 8'b0_101_1_010, 8'b0_111_1_011, 8'b0_010_1_000,
    8'b1_000_0_000, 8'b1_101_0_010, 8'b1_111_0_011, 8'b1_001_1_000
  };

  logic clk = 1'b0, osc_clk = 1'b0;
  logic rst_n, tick, por_pulse, bor_pulse, pm_exit_pulse, pwrt_en_n, ext_rst_n;
  logic [2:0] clk_mode;
  logic core_reset, pwrt_done, ost_done, pll_done;
  int   errors = 0, checks = 0, tick_div = 1;

  always #10 clk = ~clk;
  always #15 osc_clk = ~osc_clk;

  startup_hold_seq #(.PWRT_TICKS(P), .PLL_TICKS(L), .OSC_CYCLES(O)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_clk(osc_clk),
    .por_pulse(por_pulse), .bor_pulse(bor_pulse), .pm_exit_pulse(pm_exit_pulse),
    .clk_mode(clk_mode), .pwrt_en_n(pwrt_en_n), .ext_rst_n(ext_rst_n),
    .core_reset(core_reset), .pwrt_done(pwrt_done), .ost_done(ost_done),
    .pll_done(pll_done)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // nominal hold in clk cycles, from the requirements
  function automatic int nominal(input logic wake, input logic [2:0] m, input logic en_n);
    int n = 0;
    if (!wake && !en_n) n += P + 1;
    if (m[2])           n += (O * 3) / 2;
    if (m == 3'd7)      n += L + 1;
    return n;
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) por_pulse = 1'b1;
    else if (which == 1) bor_pulse = 1'b1;
    else pm_exit_pulse = 1'b1;
    @(negedge clk);
    por_pulse = 1'b0; bor_pulse = 1'b0; pm_exit_pulse = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (core_reset && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_len(input int n, input int lo, input int hi, input string tag);
    check(n >= lo && n <= hi, tag, n, lo);
  endtask

  initial begin
    int tc = 0;
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick = (tc == 0);
      tc = (tc + 1 >= tick_div) ? 0 : tc + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n, lo, hi;
    string tag;
    rst_n = 1'b0; por_pulse = 1'b0; bor_pulse = 1'b0; pm_exit_pulse = 1'b0;
    clk_mode = 3'd0; pwrt_en_n = 1'b0; ext_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(core_reset == 1'b1, "R1 core_reset", core_reset, 1);
    check({pwrt_done, ost_done, pll_done} == 3'b000, "R1 flags",
          {pwrt_done, ost_done, pll_done}, 0);
    // R11 wake before first power-on is ignored
    pulse(2);
    repeat (10) @(negedge clk);
    check(core_reset == 1'b1, "R11 wake before power-on", core_reset, 1);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      clk_mode  = VEC[i][6:4];
      pwrt_en_n = VEC[i][3];
      pulse(VEC[i][7] ? 2 : 0);
      measure(n);
      if (VEC[i][7])             tag = "R7";
      else if (VEC[i][3])        tag = "R3";
      else if (VEC[i][6:4] == 7) tag = "R5";
      else if (VEC[i][6])        tag = "R4";
      else                       tag = "R6";
      lo = nominal(VEC[i][7], VEC[i][6:4], VEC[i][3]);
      hi = (lo == 0) ? 2 : lo + 20;
      check_len(n, lo, hi, {tag, " hold length"});
      check({pwrt_done, ost_done, pll_done} == VEC[i][2:0], {tag, " R2 stage flags"},
            {pwrt_done, ost_done, pll_done}, VEC[i][2:0]);
      repeat (3) @(negedge clk);
    end

    // R12 sparse ticks stretch the power-up stage
    tick_div = 4; clk_mode = 3'd0; pwrt_en_n = 1'b0;
    pulse(0);
    measure(n);
    check_len(n, 4 * P - 4, 4 * P + 20, "R12 tick gated hold");
    tick_div = 1;
    repeat (3) @(negedge clk);

    // R10 configuration change after start has no effect
    clk_mode = 3'd0; pwrt_en_n = 1'b0;
    pulse(0);
    clk_mode = 3'd7; pwrt_en_n = 1'b1;
    measure(n);
    check_len(n, P + 1, P + 21, "R10 hold length");
    check({pwrt_done, ost_done, pll_done} == 3'b100, "R10 flags",
          {pwrt_done, ost_done, pll_done}, 4);
    repeat (3) @(negedge clk);

    // R9 brown-out during the settle stage restarts
    clk_mode = 3'd4; pwrt_en_n = 1'b0;
    pulse(0);
    n = 0;
    while (!pwrt_done && n < 500) begin @(negedge clk); n++; end
    repeat (5) @(negedge clk);
    check(pwrt_done && core_reset, "R9 in settle stage", pwrt_done, 1);
    pulse(1);
    check(core_reset == 1'b1, "R9 reasserted", core_reset, 1);
    check({pwrt_done, ost_done, pll_done} == 3'b000, "R9 flags cleared",
          {pwrt_done, ost_done, pll_done}, 0);
    measure(n);
    lo = nominal(1'b0, 3'd4, 1'b0);
    check_len(n, lo, lo + 20, "R9 full rerun");
    repeat (3) @(negedge clk);

    // R11 wake pulse mid-sequence ignored
    clk_mode = 3'd0; pwrt_en_n = 1'b0;
    pulse(0);
    repeat (5) @(negedge clk);
    pulse(2);
    measure(n);
    check_len(n + 6, P + 1, P + 21, "R11 hold unchanged");
    check(pwrt_done == 1'b1, "R11 flags", pwrt_done, 1);
    repeat (3) @(negedge clk);

    // R8 pin held low beyond the sequence
    ext_rst_n = 1'b0;
    clk_mode = 3'd0; pwrt_en_n = 1'b0;
    pulse(0);
    repeat (P + 30) @(negedge clk);
    check(core_reset == 1'b1, "R8 held by pin", core_reset, 1);
    check(pwrt_done == 1'b1, "R8 sequence complete", pwrt_done, 1);
    ext_rst_n = 1'b1;
    @(negedge clk);
    check(core_reset == 1'b1, "R8 one cycle after pin", core_reset, 1);
    @(negedge clk);
    check(core_reset == 1'b0, "R8 release after pin", core_reset, 0);

    finish_run();
  end

endmodule